// File: doc/BRIEF.md
# Orbit Pulse Synchronizer and Stretcher

This block conditions one revolution-marker (orbit) channel against the bunch clock of its ring. An asynchronous orbit input is brought into the bunch-clock domain through a two-flop synchronizer. It is then shifted by a programmable number of whole clock periods so that the sampling point can be moved away from the input transition. Each rising edge becomes a one-cycle start strobe.

The start strobe loads a stretch counter, which holds the output high for a programmable number of clock periods. A second programmable delay then shifts the stretched pulse before it is registered onto the output pin. A new edge that arrives while a pulse is being stretched reloads the counter, so the pulse is extended.

A source select replaces the external input with an internal free-running period counter. This keeps the downstream orbit timing alive when no external orbit is present. The counter restarts from zero whenever the source select changes. All settings are plain configuration inputs.

Top module: `orbit_sync_stretch`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `orbitOut` is low; an asynchronous reset during a stretched pulse forces `orbitOut` low at once.
- R2: With both delays at zero, `orbitOut` rises on the fourth rising clock edge that samples `orbitIn` high. `inDelaySel` = D (0 to 15) moves that rise later by D cycles.
- R3: One rising edge of `orbitIn` produces exactly one stretched pulse, however many cycles the input stays high.
- R4: A pulse lasts `stretchLen` clock cycles (1 to 4095). A `stretchLen` of 0 gives a pulse of one cycle.
- R5: A rising edge that is detected while a pulse is still being stretched reloads the full length. The output then stays high without a gap until `stretchLen` cycles after the later start.
- R6: With `useInternal` = 1 and `periodLen` = P (P at least 2), the internal counter makes one start every P cycles. A `periodLen` of 0 or 1 makes a start every cycle.
- R7: A change of `useInternal` restarts the internal counter at zero. After a switch to internal mode, the first `orbitOut` rise comes P+2 cycles after the switching edge. In internal mode `orbitIn` has no effect, and after a switch back to external mode no internal pulses remain.
- R8: `outDelaySel` = E (0 to 15) moves the whole stretched pulse E cycles later without changing its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock of the channel |
| rstN | input | 1 | Asynchronous active-low reset |
| orbitIn | input | 1 | Asynchronous external orbit pulse |
| useInternal | input | 1 | 1 selects the internal period counter as source |
| inDelaySel | input | 4 | Delay applied before edge detection, in clock cycles |
| outDelaySel | input | 4 | Delay applied after stretching, in clock cycles |
| stretchLen | input | 12 | Output pulse length in clock cycles (0 acts as 1) |
| periodLen | input | 16 | Internal counter period in clock cycles |
| orbitOut | output | 1 | Synchronized, stretched, delayed orbit pulse |

## Verification
The assertions check the local relations on every cycle. These are: a one-stage tap that follows its input by exactly one cycle, a detected edge that lasts exactly one cycle, a stretch counter that loads the right length and keeps the output high while counting, and an internal counter that steps by one and restarts on a source change. Only the bench scenarios can show the end-to-end timing. That covers the four-cycle base latency, the sum of the two delays, pulse lengths including the zero case, continuous output on a retrigger, the spacing of internal pulses, and the blindness to `orbitIn` in internal mode.

// File: rtl/orbit_sync_pkg.sv
package orbit_sync_pkg;

  // Strobes from the control side to the pulse datapath.
  typedef struct packed {
    logic start;   // one-cycle request to (re)load the stretch counter
  } orbitStrobes_t;

endpackage

// File: rtl/orbit_tap_delay.sv
// Tapped shift register: dout equals din delayed by sel clock cycles.
module orbit_tap_delay #(
  parameter int DEPTH = 16,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);

  localparam int STAGES = DEPTH - 1;

  logic [STAGES-1:0] stages;
  logic [SEL_W-1:0]  tapIdx;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stages <= '0;
        else       stages <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stages <= '0;
        else       stages <= {stages[STAGES-2:0], din};
      end
    end
  endgenerate

  always_comb begin
    tapIdx = sel - 1'b1;
    dout   = (sel == '0) ? din : stages[tapIdx];
  end

  // A one-stage tap must reproduce the input of the previous cycle (R2, R8).
  p_one_stage_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sel == SEL_W'(1)) |-> (dout == $past(din)));

endmodule

// File: rtl/orbit_sync_ctrl.sv
// Source side: synchronizer, input delay, edge detect, internal period counter.
module orbit_sync_ctrl
  import orbit_sync_pkg::*;
#(
  parameter int DELAY_DEPTH = 16,
  parameter int PERIOD_W    = 16,
  localparam int SEL_W = $clog2(DELAY_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                orbitIn,
  input  logic                useInternal,
  input  logic [SEL_W-1:0]    inDelaySel,
  input  logic [PERIOD_W-1:0] periodLen,
  output orbitStrobes_t       strobes
);

  logic syncA, syncB;
  logic inTap, prevTap, extStrobe;
  logic [PERIOD_W-1:0] periodCnt, lastVal;
  logic selPrev, intStrobe;

  // Two-flop synchronizer into the bunch-clock domain.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= orbitIn;
      syncB <= syncA;
    end
  end

  orbit_tap_delay #(.DEPTH(DELAY_DEPTH)) u_inDelay (
    .clk  (clk),
    .rstN (rstN),
    .din  (syncB),
    .sel  (inDelaySel),
    .dout (inTap)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTap <= 1'b0;
    else       prevTap <= inTap;
  end

  assign extStrobe = inTap & ~prevTap;

  // Internal free-running counter; period 0 behaves like period 1.
  assign lastVal   = (periodLen == '0) ? '0 : periodLen - 1'b1;
  assign intStrobe = useInternal && (periodCnt >= lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      selPrev   <= 1'b0;
    end else begin
      selPrev <= useInternal;
      if (useInternal != selPrev || !useInternal) periodCnt <= '0;
      else if (periodCnt >= lastVal)              periodCnt <= '0;
      else                                        periodCnt <= periodCnt + 1'b1;
    end
  end

  always_comb strobes.start = useInternal ? intStrobe : extStrobe;

  // A detected edge lasts exactly one cycle (R3).
  p_edge_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    extStrobe |=> !extStrobe);

  // A source change restarts the counter (R7).
  p_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (useInternal != $past(useInternal)) |=> (periodCnt == '0));

  // Below the wrap point, the counter advances by one per cycle (R6).
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (useInternal && $past(useInternal) && $stable(periodLen)
      && $past(periodCnt) < $past(lastVal) && $past(selPrev) == $past(useInternal))
      |-> (periodCnt == $past(periodCnt) + 1'b1));

endmodule

// File: rtl/orbit_stretch_path.sv
// Pulse datapath: retriggerable stretch counter, output delay, output register.
module orbit_stretch_path
  import orbit_sync_pkg::*;
#(
  parameter int DELAY_DEPTH = 16,
  parameter int STRETCH_W   = 12,
  localparam int SEL_W = $clog2(DELAY_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  orbitStrobes_t        strobes,
  input  logic [STRETCH_W-1:0] stretchLen,
  input  logic [SEL_W-1:0]     outDelaySel,
  output logic                 orbitOut
);

  logic [STRETCH_W-1:0] remaining, loadVal;
  logic stretched, outTap;

  assign loadVal   = (stretchLen == '0) ? STRETCH_W'(1) : stretchLen;
  assign stretched = (remaining != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              remaining <= '0;
    else if (strobes.start) remaining <= loadVal;
    else if (stretched)     remaining <= remaining - 1'b1;
  end

  orbit_tap_delay #(.DEPTH(DELAY_DEPTH)) u_outDelay (
    .clk  (clk),
    .rstN (rstN),
    .din  (stretched),
    .sel  (outDelaySel),
    .dout (outTap)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) orbitOut <= 1'b0;
    else       orbitOut <= outTap;
  end

  // A start, including a retrigger, loads the full length (R4, R5).
  p_load_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.start |=> (remaining == (($past(stretchLen) == '0) ? STRETCH_W'(1) : $past(stretchLen))));

  // With more than one cycle left, the pulse stays high next cycle (R4).
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (remaining > STRETCH_W'(1)) |=> stretched);

endmodule

// File: rtl/orbit_sync_stretch.sv
module orbit_sync_stretch
  import orbit_sync_pkg::*;
#(
  parameter int DELAY_DEPTH = 16,
  parameter int STRETCH_W   = 12,
  parameter int PERIOD_W    = 16,
  localparam int SEL_W = $clog2(DELAY_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 orbitIn,
  input  logic                 useInternal,
  input  logic [SEL_W-1:0]     inDelaySel,
  input  logic [SEL_W-1:0]     outDelaySel,
  input  logic [STRETCH_W-1:0] stretchLen,
  input  logic [PERIOD_W-1:0]  periodLen,
  output logic                 orbitOut
);

  orbitStrobes_t strobes;

  orbit_sync_ctrl #(.DELAY_DEPTH(DELAY_DEPTH), .PERIOD_W(PERIOD_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .orbitIn     (orbitIn),
    .useInternal (useInternal),
    .inDelaySel  (inDelaySel),
    .periodLen   (periodLen),
    .strobes     (strobes)
  );

  orbit_stretch_path #(.DELAY_DEPTH(DELAY_DEPTH), .STRETCH_W(STRETCH_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .stretchLen  (stretchLen),
    .outDelaySel (outDelaySel),
    .orbitOut    (orbitOut)
  );

  // Output stays low while reset is held (R1).
  p_reset_low_r1: assert property (@(posedge clk) !rstN |-> !orbitOut);

endmodule

// File: tb/orbit_sync_stretch_test.sv
module orbit_sync_stretch_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // Columns: inDelay, outDelay, stretch, inputWidth, expFirst, expLen
  localparam int VEC [NVEC][6] = '{
    '{0,  0,  1,  1,  4,  1},
    '{3,  0,  5,  2,  7,  5},
    '{0,  6,  8, 20, 10,  8},
    '{15, 15, 2,  1, 34,  2},
    '{2,  1,  0,  3,  7,  1},
    '{0,  0, 30,  1,  4, 30},
    '{7,  0, 12,  4, 11, 12}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic orbitIn = 1'b0;
  logic useInternal = 1'b0;
  logic [3:0] inDelaySel = '0;
  logic [3:0] outDelaySel = '0;
  logic [11:0] stretchLen = 12'd1;
  logic [15:0] periodLen = 16'd7;
  logic orbitOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  orbit_sync_stretch uut (
    .clk(clk), .rstN(rstN), .orbitIn(orbitIn), .useInternal(useInternal),
    .inDelaySel(inDelaySel), .outDelaySel(outDelaySel),
    .stretchLen(stretchLen), .periodLen(periodLen), .orbitOut(orbitOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pulses orbitIn for width cycles (optional second one-cycle pulse at idx second),
  // then records first high index and number of high cycles.
  task automatic runPulse(input int d, input int e, input int n, input int width,
                          input int second, output int first, output int len);
    @(negedge clk);
    inDelaySel = 4'(d); outDelaySel = 4'(e); stretchLen = 12'(n);
    idle(40);
    orbitIn = 1'b1;
    first = -1; len = 0;
    for (int idx = 1; idx <= 80; idx++) begin
      @(negedge clk);
      if (orbitOut) begin
        if (first < 0) first = idx;
        len++;
      end
      if (idx == width) orbitIn = 1'b0;
      if (second > 0 && idx == second) orbitIn = 1'b1;
      if (second > 0 && idx == second + 1) orbitIn = 1'b0;
    end
  endtask

  initial begin
    int first, len, cnt;
    // R1: reset state
    idle(4);
    check("R1 low in reset", int'(orbitOut), 0);
    rstN = 1'b1;
    idle(3);
    check("R1 low after reset", int'(orbitOut), 0);

    // Vector table: R2 latency/input delay, R3 single pulse, R4 length, R8 output delay
    for (int v = 0; v < NVEC; v++) begin
      runPulse(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0, first, len);
      check($sformatf("R2/R8 onset vec%0d", v), first, VEC[v][4]);
      check($sformatf("R3/R4 length vec%0d", v), len, VEC[v][5]);
    end

    // R5: retrigger at idx 5 with stretch 10 -> continuous 4..17
    runPulse(0, 0, 10, 1, 4, first, len);
    check("R5 retrigger onset", first, 4);
    check("R5 retrigger length", len, 14);

    // R6/R7: switch to internal, period 7, orbitIn pulsed (must be ignored)
    @(negedge clk);
    stretchLen = 12'd1; periodLen = 16'd7; inDelaySel = '0; outDelaySel = '0;
    idle(40);
    useInternal = 1'b1;
    first = -1; cnt = 0;
    for (int idx = 1; idx <= 60; idx++) begin
      @(negedge clk);
      if (orbitOut) begin
        if (first < 0) first = idx;
        cnt++;
      end
      orbitIn = (idx >= 20 && idx < 23);
    end
    check("R7 first internal pulse", first, 9);
    check("R6 internal pulse count (orbitIn ignored R7)", cnt, 8);

    // R6: period 1 -> start every cycle
    periodLen = 16'd1;
    idle(10);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (orbitOut) cnt++;
    end
    check("R6 period one continuous", cnt, 20);

    // R6: period 0 behaves like 1
    periodLen = 16'd0;
    idle(10);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (orbitOut) cnt++;
    end
    check("R6 period zero continuous", cnt, 20);

    // R7: back to external -> quiet
    useInternal = 1'b0; periodLen = 16'd7;
    idle(10);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (orbitOut) cnt++;
    end
    check("R7 quiet after switch back", cnt, 0);

    // R1: reset during a long pulse
    stretchLen = 12'd30;
    idle(5);
    orbitIn = 1'b1;
    idle(10);
    orbitIn = 1'b0;
    check("R1 pulse active before reset", int'(orbitOut), 1);
    rstN = 1'b0;
    #1;
    check("R1 async reset clears output", int'(orbitOut), 0);
    idle(3);
    rstN = 1'b1;
    idle(5);
    check("R1 low after mid-pulse reset", int'(orbitOut), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule